// File: doc/BRIEF.md
# Eager Stack Transfer Arbitration Policy

This block sits beside a stack cache that spills and fills in the background, using memory slots no other requester has claimed. Each time a free slot is offered it decides whether the transfer engine may start an eager spill, an eager fill, or nothing. It looks at two fill levels of the cache: the full occupancy (all words held on chip) and the effective occupancy (words not yet known to match main memory). It also receives the cache capacity, one pulse per reserve command and one pulse per ensure command.

A spill is possible when the effective occupancy is non-zero. A fill is possible when the occupancy is below the capacity. A mode input picks one of five policies: spill only, fill only, strict turn-taking, turn-taking bounded by half-capacity thresholds, or a saturating counter that guesses whether the program is descending the call chain (reserves) or climbing it (ensures). The permit outputs are combinational and are only valid while the slot strobe is high. No data flows through the block, so all pins are plain level or pulse signals with no valid/ready handshake and no back-pressure.

Top module: `eager_xfer_arbiter`

## Requirements
- R1: Neither permit is ever high while `slot_grant` is low, and the two permits are never high in the same cycle.
- R2: Mode 0 (spill only): `permit_spill` equals `slot_grant` AND (`eff_occ` != 0). `permit_fill` stays low.
- R3: Mode 1 (fill only): `permit_fill` equals `slot_grant` AND (`occ` < `cache_size`). `permit_spill` stays low.
- R4: Mode 2 (alternate): when both kinds are possible on consecutive granted slots, the permits take turns. Spill comes first after reset or after a mode change. The turn moves only on a granted slot where both were possible.
- R5: In modes 2 and 3, when only one kind is possible, that kind is permitted and the turn is left as it was.
- R6: Mode 3 (threshold): a spill is only a candidate while `eff_occ` > floor(`cache_size`/2).
- R7: Mode 3 (threshold): a fill is only a candidate while `occ` < floor(`cache_size`/2). Candidates take turns as in R4.
- R8: The prediction counter adds one on a reserve pulse and subtracts one on an ensure pulse. It saturates at 0 and at 2^CNT_W-1. Both pulses in the same cycle leave it unchanged. It resets to floor((2^CNT_W-1)/2), which is 0 at the default width of 1.
- R9: Mode 4 (predict): a spill is permitted only when the counter is at its maximum, and a fill only when it is at 0. The usual possibility condition must also hold.
- R10: Mode codes 5, 6 and 7 permit nothing.
- R11: The `mode` input is registered. A new value governs permits from the cycle after it is presented. A mode change returns the counter to its reset value and the turn to spill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Policy select (0 spill, 1 fill, 2 alternate, 3 threshold, 4 predict) |
| occ | input | OCC_W | Words held in the cache |
| eff_occ | input | OCC_W | Words held that are not coherent with memory |
| cache_size | input | OCC_W | Cache capacity in words |
| reserve_pulse | input | 1 | One-cycle pulse per reserve command |
| ensure_pulse | input | 1 | One-cycle pulse per ensure command |
| slot_grant | input | 1 | A free memory slot is offered this cycle |
| permit_spill | output | 1 | Eager spill may be issued in this slot |
| permit_fill | output | 1 | Eager fill may be issued in this slot |

## Verification
The bench targets the threshold boundaries: effective occupancy exactly at half capacity, occupancy exactly at half, and an odd capacity. A design with an off-by-one comparison would permit one extra eager transfer, or withhold one. It checks that the turn moves only when both kinds competed. A design that flipped the turn on every grant would hand a later contested slot to the wrong kind. It also drives the counter into both saturation limits, applies simultaneous reserve and ensure pulses, and changes mode while the counter and turn are away from reset. A design that kept stale state across a mode change would permit the wrong kind on the first slot afterwards.

// File: rtl/eager_arb_pkg.sv
package eager_arb_pkg;
  typedef enum logic [2:0] {
    POL_SPILL   = 3'd0,
    POL_FILL    = 3'd1,
    POL_ALT     = 3'd2,
    POL_THRESH  = 3'd3,
    POL_PREDICT = 3'd4
  } policy_e;
endpackage

// File: rtl/eager_possible.sv
module eager_possible #(
  parameter int OCC_W = 8
) (
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] eff_occ,
  input  logic [OCC_W-1:0] cache_size,
  output logic             spill_ok,
  output logic             fill_ok,
  output logic             spill_thr,
  output logic             fill_thr
);
  logic [OCC_W-1:0] half;

  always_comb begin
    half      = cache_size >> 1;
    spill_ok  = (eff_occ != '0);
    fill_ok   = (occ < cache_size);
    spill_thr = spill_ok && (eff_occ > half);
    fill_thr  = fill_ok && (occ < half);
  end
endmodule

// File: rtl/eager_pred_counter.sv
module eager_pred_counter #(
  parameter int CNT_W = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  input  logic dec,
  output logic at_max,
  output logic at_min
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIDV = MAXV >> 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= MIDV;
    end else if (inc && !dec && cnt != MAXV) begin
      cnt <= cnt + 1'b1;
    end else if (dec && !inc && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    at_max = (cnt == MAXV);
    at_min = (cnt == '0);
  end

  assert_sat_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && inc && !dec && !clear) |=> at_max);
  assert_sat_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_min && dec && !inc && !clear) |=> at_min);
  assert_clear_mid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == MIDV));
endmodule

// File: rtl/eager_turn_pick.sv
module eager_turn_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic grant,
  input  logic cand_spill,
  input  logic cand_fill,
  output logic pick_spill,
  output logic pick_fill
);
  logic turn_fill;
  logic both;

  always_comb begin
    both       = cand_spill && cand_fill;
    pick_spill = both ? !turn_fill : cand_spill;
    pick_fill  = both ? turn_fill  : cand_fill;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      turn_fill <= 1'b0;
    end else if (grant && both) begin
      turn_fill <= !turn_fill;
    end
  end

  assert_turn_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && both && !clear) |=> (turn_fill != $past(turn_fill)));
  assert_turn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(grant && both) && !clear) |=> $stable(turn_fill));
endmodule

// File: rtl/eager_xfer_arbiter.sv
module eager_xfer_arbiter #(
  parameter int OCC_W = 8,
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] eff_occ,
  input  logic [OCC_W-1:0] cache_size,
  input  logic             reserve_pulse,
  input  logic             ensure_pulse,
  input  logic             slot_grant,
  output logic             permit_spill,
  output logic             permit_fill
);
  import eager_arb_pkg::*;

  logic [2:0] mode_q;
  logic       mode_chg;
  logic       spill_ok, fill_ok, spill_thr, fill_thr;
  logic       cnt_max, cnt_min;
  logic       cand_spill, cand_fill;
  logic       pick_spill, pick_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= POL_SPILL;
    else        mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);

  eager_possible #(.OCC_W(OCC_W)) u_possible (
    .occ(occ), .eff_occ(eff_occ), .cache_size(cache_size),
    .spill_ok(spill_ok), .fill_ok(fill_ok),
    .spill_thr(spill_thr), .fill_thr(fill_thr)
  );

  eager_pred_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clear(mode_chg),
    .inc(reserve_pulse), .dec(ensure_pulse),
    .at_max(cnt_max), .at_min(cnt_min)
  );

  always_comb begin
    cand_spill = 1'b0;
    cand_fill  = 1'b0;
    case (mode_q)
      POL_SPILL:   cand_spill = spill_ok;
      POL_FILL:    cand_fill  = fill_ok;
      POL_ALT: begin
        cand_spill = spill_ok;
        cand_fill  = fill_ok;
      end
      POL_THRESH: begin
        cand_spill = spill_thr;
        cand_fill  = fill_thr;
      end
      POL_PREDICT: begin
        cand_spill = spill_ok && cnt_max;
        cand_fill  = fill_ok && cnt_min;
      end
      default: begin
        cand_spill = 1'b0;
        cand_fill  = 1'b0;
      end
    endcase
  end

  eager_turn_pick u_turn (
    .clk(clk), .rst_n(rst_n), .clear(mode_chg), .grant(slot_grant),
    .cand_spill(cand_spill), .cand_fill(cand_fill),
    .pick_spill(pick_spill), .pick_fill(pick_fill)
  );

  assign permit_spill = slot_grant && pick_spill;
  assign permit_fill  = slot_grant && pick_fill;

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({permit_spill, permit_fill}));
  assert_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_grant |-> !(permit_spill || permit_fill));
  assert_spill_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_SPILL) |-> !permit_fill);
  assert_fill_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_FILL) |-> !permit_spill);
  assert_thr_spill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_THRESH && permit_spill) |-> (eff_occ > (cache_size >> 1)));
  assert_thr_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_THRESH && permit_fill) |-> (occ < (cache_size >> 1)));
  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q > POL_PREDICT) |-> !(permit_spill || permit_fill));
  assert_possible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    permit_spill |-> (eff_occ != '0));
endmodule

// File: tb/eager_xfer_arbiter_bench.sv
module eager_xfer_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OCC_W = 8;

  typedef struct packed {
    logic [2:0] m;
    logic [7:0] occ;
    logic [7:0] eff;
    logic [7:0] size;
    logic       g;
    logic       s;
    logic       f;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd4,  8'd3,  8'd16, 1'b1, 1'b1, 1'b0},  // R2 spill possible
    '{3'd0, 8'd4,  8'd0,  8'd16, 1'b1, 1'b0, 1'b0},  // R2 nothing dirty
    '{3'd1, 8'd4,  8'd3,  8'd16, 1'b1, 1'b0, 1'b1},  // R3 fill possible
    '{3'd1, 8'd16, 8'd3,  8'd16, 1'b1, 1'b0, 1'b0},  // R3 cache full
    '{3'd0, 8'd4,  8'd3,  8'd16, 1'b0, 1'b0, 1'b0},  // R1 no grant
    '{3'd5, 8'd4,  8'd3,  8'd16, 1'b1, 1'b0, 1'b0},  // R10
    '{3'd7, 8'd4,  8'd3,  8'd16, 1'b1, 1'b0, 1'b0},  // R10
    '{3'd3, 8'd12, 8'd10, 8'd16, 1'b1, 1'b1, 1'b0},  // R6 above half
    '{3'd3, 8'd12, 8'd8,  8'd16, 1'b1, 1'b0, 1'b0},  // R6 at half
    '{3'd3, 8'd7,  8'd0,  8'd16, 1'b1, 1'b0, 1'b1},  // R7 below half
    '{3'd3, 8'd8,  8'd0,  8'd16, 1'b1, 1'b0, 1'b0},  // R7 at half
    '{3'd2, 8'd16, 8'd5,  8'd16, 1'b1, 1'b1, 1'b0},  // R5 only spill
    '{3'd2, 8'd4,  8'd0,  8'd16, 1'b1, 1'b0, 1'b1},  // R5 only fill
    '{3'd3, 8'd15, 8'd7,  8'd15, 1'b1, 1'b0, 1'b0},  // R6 odd size, half=7
    '{3'd3, 8'd15, 8'd8,  8'd15, 1'b1, 1'b1, 1'b0}   // R6 odd size above
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       mode;
  logic [OCC_W-1:0] occ, eff_occ, cache_size;
  logic             reserve_pulse, ensure_pulse, slot_grant;
  logic             permit_spill, permit_fill;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eager_xfer_arbiter #(.OCC_W(OCC_W), .CNT_W(1)) u_eager_xfer_arbiter (
    .clk(clk), .rst_n(rst_n), .mode(mode), .occ(occ), .eff_occ(eff_occ),
    .cache_size(cache_size), .reserve_pulse(reserve_pulse),
    .ensure_pulse(ensure_pulse), .slot_grant(slot_grant),
    .permit_spill(permit_spill), .permit_fill(permit_fill)
  );

  task automatic check(input string req, input logic es, input logic ef);
    n_checks++;
    if (permit_spill !== es || permit_fill !== ef) begin
      n_fails++;
      $display("FAIL %s: spill/fill = %b%b expected %b%b", req,
               permit_spill, permit_fill, es, ef);
    end
  endtask

  // drive levels with grant low, let one edge pass, then raise grant
  task automatic setup(input logic [2:0] m, input logic [7:0] o,
                       input logic [7:0] e, input logic [7:0] sz);
    @(negedge clk);
    slot_grant = 1'b0; mode = m; occ = o; eff_occ = e; cache_size = sz;
    @(negedge clk);
  endtask

  task automatic pulse(input logic r, input logic en);
    @(negedge clk);
    slot_grant = 1'b0; reserve_pulse = r; ensure_pulse = en;
    @(negedge clk);
    reserve_pulse = 1'b0; ensure_pulse = 1'b0;
  endtask

  task automatic grant_check(input string req, input logic es, input logic ef);
    slot_grant = 1'b1;
    #1 check(req, es, ef);
    @(negedge clk);
    slot_grant = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; occ = 8'd4; eff_occ = 8'd3; cache_size = 8'd16;
    reserve_pulse = 1'b0; ensure_pulse = 1'b0; slot_grant = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset idle", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].m, VECS[i].occ, VECS[i].eff, VECS[i].size);
      slot_grant = VECS[i].g;
      #1 check($sformatf("vector %0d", i), VECS[i].s, VECS[i].f);
    end

    // R4: alternate with both possible, grant held across edges
    setup(3'd2, 8'd4, 8'd3, 8'd16);
    slot_grant = 1'b1;
    #1 check("R4 first spill", 1'b1, 1'b0);
    @(negedge clk); #1 check("R4 then fill", 1'b0, 1'b1);
    @(negedge clk); #1 check("R4 spill again", 1'b1, 1'b0);
    @(negedge clk); #1 check("R4 fill again", 1'b0, 1'b1);
    @(negedge clk); slot_grant = 1'b0;   // turn now points at spill

    // R5: turn kept when only one kind possible
    grant_check("R5 spill contested", 1'b1, 1'b0);  // turn -> fill
    eff_occ = 8'd0;
    grant_check("R5 fill alone", 1'b0, 1'b1);
    grant_check("R5 fill alone twice", 1'b0, 1'b1);
    eff_occ = 8'd3;
    grant_check("R5 turn unchanged", 1'b0, 1'b1);
    grant_check("R5 then spill", 1'b1, 1'b0);
    grant_check("R5 turn on fill", 1'b0, 1'b1);

    // R11: move turn to fill, change mode, turn restarts at spill
    grant_check("R11 prep spill", 1'b1, 1'b0);
    setup(3'd3, 8'd4, 8'd10, 8'd16);
    grant_check("R11 turn reset R7", 1'b1, 1'b0);
    grant_check("R7 threshold alternates", 1'b0, 1'b1);

    // R8/R9: counter mode, default width 1, resets to 0
    setup(3'd4, 8'd4, 8'd3, 8'd16);
    grant_check("R9 counter low fills", 1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    grant_check("R8 reserve raises", 1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    grant_check("R8 saturate high", 1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    grant_check("R8 both pulses hold", 1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    grant_check("R8 ensure lowers", 1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    grant_check("R8 saturate low", 1'b0, 1'b1);
    eff_occ = 8'd0;
    pulse(1'b1, 1'b0);
    grant_check("R9 high but nothing dirty", 1'b0, 1'b0);
    eff_occ = 8'd3;
    setup(3'd2, 8'd4, 8'd3, 8'd16);
    setup(3'd4, 8'd4, 8'd3, 8'd16);
    grant_check("R11 counter reset", 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule